// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Timer

This block produces a single output pulse of programmable length, measured in clock cycles, each time it sees a valid trigger. It is a synchronous, counter-based replacement for a retriggerable monostable multivibrator. There are two trigger inputs. `fall_trig_i` fires on a falling edge, but only while `rise_trig_i` is high. `rise_trig_i` fires on a rising edge, but only while `fall_trig_i` is low. An active-low clear input, `clr_n_i`, ends a running pulse and blocks triggering while it is low. Releasing it also fires the block when the two trigger inputs are already in their armed state.

A trigger that arrives during a pulse reloads the full length, so the pulse can be held high indefinitely. The three control inputs are asynchronous. Each passes through its own synchroniser before edge detection. A dual-channel part is built from two instances.

Top module: `retrig_oneshot`

## Requirements
- R1: After the synchronous active-low reset `rst_n`, `pulse_o` is 0 and `pulse_n_o` is 1.
- R2: A falling edge on `fall_trig_i` with `rise_trig_i` = 1 and `clr_n_i` = 1 fires a pulse. With default parameters, for an input changed just before clock edge k, `pulse_o` is 1 after edge k+2 and stays 1 for exactly `pulse_len_i` cycles.
- R3: A falling edge on `fall_trig_i` while `rise_trig_i` = 0 fires no pulse.
- R4: A rising edge on `rise_trig_i` with `fall_trig_i` = 0 fires a pulse of `pulse_len_i` cycles. The same edge with `fall_trig_i` = 1 fires none.
- R5: A valid trigger during a running pulse restarts the full length. The pulse then ends `pulse_len_i` cycles after the second trigger is detected.
- R6: `clr_n_i` going low ends a running pulse. `pulse_o` is 0 two clock edges after the input change.
- R7: Trigger edges that occur while `clr_n_i` is low fire no pulse. Releasing clear with `rise_trig_i` = 0 fires none either.
- R8: A rising edge on `clr_n_i` while `fall_trig_i` = 0 and `rise_trig_i` = 1 fires a pulse of `pulse_len_i` cycles.
- R9: `pulse_n_o` is always the complement of `pulse_o`.
- R10: `pulse_len_i` is sampled on the cycle the trigger is detected. Changing it later does not alter the length of that pulse.
- R11: A trigger detected while `pulse_len_i` = 0 produces no high cycle on `pulse_o`.
- R12: A falling edge on `fall_trig_i` and a rising edge on `rise_trig_i` detected in the same cycle fire one pulse of `pulse_len_i` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fall_trig_i | input | 1 | Falling-edge trigger, enabled while `rise_trig_i` is high |
| rise_trig_i | input | 1 | Rising-edge trigger, enabled while `fall_trig_i` is low |
| clr_n_i | input | 1 | Active-low clear; its release can fire a pulse |
| pulse_len_i | input | LEN_BITS | Pulse length in clock cycles |
| pulse_o | output | 1 | High for the duration of the pulse |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
Every input change passes through two synchroniser flops before any result appears. The bench therefore drives stimuli on the falling clock edge and counts falling edges from the change.

A pulse started by a trigger driven at falling edge 0 is first seen high at falling edge 3. A clear driven at falling edge 0 is first seen low at falling edge 2.

Pulse lengths are measured by a bench monitor that samples `pulse_o` shortly after each rising edge. It records the length of the most recent completed pulse and counts the pulses. Each scenario compares these against `pulse_len_i`, or against the sum of the retrigger offset and `pulse_len_i`.

// File: rtl/oneshot_pkg.sv
// Shared types for the retriggerable one-shot.
// Assumes the three control inputs are bundled as one packed struct.
package oneshot_pkg;

    typedef struct packed {
        logic fall_trig;   // trigger that fires on a falling edge
        logic rise_trig;   // trigger that fires on a rising edge
        logic clr_n;       // active-low clear
    } ctl_t;

    // Idle levels: nothing armed, clear released
    localparam ctl_t CTL_IDLE = '{fall_trig: 1'b1, rise_trig: 1'b0, clr_n: 1'b1};

endpackage

// File: rtl/oneshot_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous level inputs.
// Assumes each bit is an independent slow level; no bus coherency is implied.
module oneshot_sync #(
    parameter int          BITS    = 3,
    parameter int          STAGES  = 2,
    parameter logic [BITS-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] async_i,
    output logic [BITS-1:0] sync_o
);

    logic [BITS-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift each input one flop further down the chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= RST_VAL;
                else if (s == 0)
                    stage_q[s] <= async_i;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/oneshot_trig.sv
// Edge detector and trigger gating for the one-shot.
// Assumes its inputs are already synchronised. The previous-level register
// tracks the inputs every cycle, so it is reloaded while clear is low and no
// false edge appears on release.
module oneshot_trig
    import oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctl_t lvl_i,
    output logic trig_o
);

    ctl_t prev_q;
    logic fall_seen;
    logic rise_seen;
    logic clr_rel;

    // Purpose: remember last cycle's levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= CTL_IDLE;
        else
            prev_q <= lvl_i;
    end

    // Purpose: detect edges and apply cross-gating; clear low blocks all
    always_comb begin
        fall_seen = prev_q.fall_trig & ~lvl_i.fall_trig & lvl_i.rise_trig;
        rise_seen = ~prev_q.rise_trig & lvl_i.rise_trig & ~lvl_i.fall_trig;
        clr_rel   = ~prev_q.clr_n & lvl_i.clr_n & ~lvl_i.fall_trig & lvl_i.rise_trig;
        trig_o    = lvl_i.clr_n & (fall_seen | rise_seen | clr_rel);
    end

endmodule

// File: rtl/oneshot_count.sv
// Down-counter that holds the pulse active for a loaded number of cycles.
// Assumes clear has priority over load. A load of zero ends any pulse.
module oneshot_count #(
    parameter int LEN_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                load_i,
    input  logic [LEN_BITS-1:0] len_i,
    output logic                busy_o
);

    logic [LEN_BITS-1:0] cnt_q;

    // Purpose: clear, reload on trigger, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear_i)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= len_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> (cnt_q == $past(len_i)));

    assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clear_i && busy_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !busy_o);

endmodule

// File: rtl/retrig_oneshot.sv
// Retriggerable one-shot: synchronises the controls, detects gated edges and
// drives a pulse of a programmable number of cycles. Assumes pulse_len_i is
// stable around the trigger detection cycle. The synchronous reset sets the
// output low.
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int LEN_BITS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_trig_i,
    input  logic                rise_trig_i,
    input  logic                clr_n_i,
    input  logic [LEN_BITS-1:0] pulse_len_i,
    output logic                pulse_o,
    output logic                pulse_n_o
);

    localparam int CTL_BITS = $bits(ctl_t);

    ctl_t raw_ctl;
    ctl_t lvl;
    logic trig;
    logic busy;

    assign raw_ctl = '{fall_trig: fall_trig_i, rise_trig: rise_trig_i, clr_n: clr_n_i};

    oneshot_sync #(
        .BITS    (CTL_BITS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_ctl),
        .sync_o  (lvl)
    );

    oneshot_trig u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .trig_o (trig)
    );

    oneshot_count #(
        .LEN_BITS (LEN_BITS)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (~lvl.clr_n),
        .load_i  (trig),
        .len_i   (pulse_len_i),
        .busy_o  (busy)
    );

    // Purpose: gate the output with clear so an abort drops it one cycle sooner
    assign pulse_o   = busy & lvl.clr_n;
    assign pulse_n_o = ~pulse_o;

    assert_rise_needs_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(trig));

    assert_zero_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && pulse_len_i == '0) |=> !pulse_o);

endmodule

// File: tb/retrig_oneshot_bench.sv
module retrig_oneshot_bench;

    localparam int LB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a = 1'b1;
    logic          b = 1'b0;
    logic          clr = 1'b1;
    logic [LB-1:0] wv = 8'd5;
    logic          q;
    logic          qn;

    int n_checks = 0;
    int n_errs   = 0;
    int run_len  = 0;
    int last_len = 0;
    int pulses   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    retrig_oneshot #(.LEN_BITS(LB), .SYNC_STAGES(2)) u_retrig_oneshot (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_trig_i (a),
        .rise_trig_i (b),
        .clr_n_i     (clr),
        .pulse_len_i (wv),
        .pulse_o     (q),
        .pulse_n_o   (qn)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: measures pulse lengths and checks the complement (R9)
    always @(posedge clk) begin
        #2;
        if (!rst_n) begin
            run_len = 0;
        end else begin
            if (qn !== ~q) check(1'b0, "R9 complement", int'(qn), int'(~q));
            if (q) run_len++;
            else if (run_len != 0) begin
                last_len = run_len;
                pulses++;
                run_len = 0;
            end
        end
    end

    task automatic wait_n(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk); b = 1'b0;
        @(negedge clk); a = 1'b1; clr = 1'b1;
        wait_n(6);
    endtask

    task automatic t_reset();
        check(q == 1'b0, "R1 pulse_o after reset", q, 0);
        check(qn == 1'b1, "R1 pulse_n_o after reset", qn, 1);
    endtask

    task automatic t_fall_trig();
        int p0;
        wv = 8'd5; p0 = pulses;
        @(negedge clk); a = 1'b0;                  // b is 0: blocked (R3)
        wait_n(12);
        check(pulses == p0 && q == 0, "R3 fall with rise_trig low", pulses, p0);
        @(negedge clk); a = 1'b1;
        wait_n(4);
        @(negedge clk); b = 1'b1;                  // a high: rise blocked (R4)
        wait_n(12);
        check(pulses == p0, "R4 rise with fall_trig high", pulses, p0);
        @(negedge clk); a = 1'b0;                  // valid fall (R2)
        wait_n(2);
        check(q == 1'b0, "R2 latency low at edge 2", q, 0);
        wait_n(1);
        check(q == 1'b1, "R2 high at edge 3", q, 1);
        wait_n(10);
        check(pulses == p0 + 1, "R2 pulse count", pulses, p0 + 1);
        check(last_len == 5, "R2 pulse length", last_len, 5);
        go_idle();
    endtask

    task automatic t_rise_trig();
        int p0;
        wv = 8'd7;
        @(negedge clk); a = 1'b0;                  // b low: no trigger
        wait_n(6);
        p0 = pulses;
        @(negedge clk); b = 1'b1;
        wait_n(3);
        check(q == 1'b1, "R4 high at edge 3", q, 1);
        wait_n(12);
        check(pulses == p0 + 1 && last_len == 7, "R4 rise pulse length", last_len, 7);
        go_idle();
    endtask

    task automatic t_retrig();
        int p0;
        wv = 8'd10;
        @(negedge clk); a = 1'b0;
        wait_n(6);
        p0 = pulses;
        @(negedge clk); b = 1'b1;                  // trigger at edge 0
        wait_n(4);
        b = 1'b0;
        wait_n(2);
        b = 1'b1;                                  // retrigger at edge 6
        wait_n(25);
        check(pulses == p0 + 1, "R5 single extended pulse", pulses, p0 + 1);
        check(last_len == 16, "R5 retriggered length", last_len, 16);
        go_idle();
    endtask

    task automatic t_clear();
        int p0;
        wv = 8'd20;
        @(negedge clk); a = 1'b0;
        wait_n(6);
        p0 = pulses;
        @(negedge clk); b = 1'b1;
        wait_n(5);
        clr = 1'b0;                                // clear at edge 5
        wait_n(1);
        check(q == 1'b1, "R6 still high one edge after clear", q, 1);
        wait_n(1);
        check(q == 1'b0 && qn == 1'b1, "R6 low two edges after clear", q, 0);
        wait_n(4);
        check(pulses == p0 + 1 && last_len == 4, "R6 aborted length", last_len, 4);
        b = 1'b0;
        wait_n(3);
        b = 1'b1;                                  // edge while clear low (R7)
        wait_n(3);
        a = 1'b1;
        wait_n(3);
        a = 1'b0;                                  // fall with b high, clear low
        wait_n(8);
        check(pulses == p0 + 1 && q == 0, "R7 triggers blocked in clear", pulses, p0 + 1);
        b = 1'b0;
        wait_n(3);
        clr = 1'b1;                                // release with b low
        wait_n(10);
        check(pulses == p0 + 1 && q == 0, "R7 release with rise_trig low", pulses, p0 + 1);
        go_idle();
    endtask

    task automatic t_clr_fire();
        int p0;
        wv = 8'd6;
        @(negedge clk); clr = 1'b0;
        wait_n(3);
        a = 1'b0; b = 1'b1;
        wait_n(4);
        p0 = pulses;
        clr = 1'b1;                                // release with a low, b high
        wait_n(3);
        check(q == 1'b1, "R8 high at edge 3 after release", q, 1);
        wait_n(8);
        check(pulses == p0 + 1 && last_len == 6, "R8 release pulse length", last_len, 6);
        go_idle();
    endtask

    task automatic t_len_sample();
        int p0;
        wv = 8'd6;
        p0 = pulses;
        @(negedge clk); a = 1'b0; b = 1'b1;        // simultaneous edges (R12)
        wait_n(4);
        wv = 8'd30;                                // change after detection (R10)
        wait_n(10);
        check(pulses == p0 + 1, "R12 one pulse for both edges", pulses, p0 + 1);
        check(last_len == 6, "R10 length sampled at trigger", last_len, 6);
        go_idle();
    endtask

    task automatic t_zero();
        int p0;
        wv = 8'd0;
        @(negedge clk); a = 1'b0;
        wait_n(6);
        p0 = pulses;
        @(negedge clk); b = 1'b1;
        wait_n(8);
        check(pulses == p0 && q == 0, "R11 zero length no pulse", pulses, p0);
        go_idle();
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        wait_n(4);
        t_fall_trig();
        t_rise_trig();
        t_retrig();
        t_clear();
        t_clr_fire();
        t_len_sample();
        t_zero();
        wait_n(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule